// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Engine

This block computes `M^E mod N` for operands of a configurable width. It walks the exponent from its lowest bit towards its highest. It keeps two working values: the running result, which starts at 1, and the running power of the base, which starts at `M`. In every step two modular multiplier units run side by side. One forms the product of the result and the power. The other squares the power. When the current exponent bit is one, the product replaces the result. Because the two operations are independent, one step costs the time of a single modular multiplication.

A mode input chooses how zero exponent bits are handled. In private mode the product is always computed and then thrown away when the bit is zero, so the work and the timing do not depend on the exponent. In public mode the product unit is not started for zero bits. An exponent length input sets how many low bits of `E` take part. The caller presents `M`, `E`, `N`, the length and the mode with a one-cycle start strobe. The block answers with the result and a one-cycle done pulse.

Top module: `modexp_top`

## Requirements
- R1: After reset, `done_o` is 0 and `res_o` is 0.
- R2: For inputs with `N` odd, `N > 1` and `M < N`, the result presented with `done_o` equals `M^E' mod N`, where `E'` is formed from the lowest `k` bits of `e_i` and `k` is the value on `nbits_i`. This holds in both modes.
- R3: When `nbits_i` is 0, the result is 1.
- R4: Bits of `e_i` at positions `k` and above have no effect on the result. A value of `nbits_i` larger than the exponent width `EW` is treated as `EW`.
- R5: `done_o` rises exactly `k*(W+2)` clock cycles after the edge that accepts `start_i`, where `k` is the effective exponent length. This latency depends on neither operand values nor exponent bits nor mode.
- R6: `priv_i = 1` selects private mode, in which the product unit runs in every step. `priv_i = 0` selects public mode, in which the product unit runs only for exponent bits equal to 1. The squaring unit runs in every step, `k` times in total.
- R7: `done_o` is high for exactly one cycle per operation. `res_o` keeps its value from that cycle until the next operation completes.
- R8: `start_i` is accepted only while the block is idle. A start asserted during an operation changes neither that operation's result nor its latency.
- R9: The result and the running power always stay in the range 0 to `N-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| priv_i | input | 1 | 1 = private (constant work), 0 = public (skip products) |
| m_i | input | W | Base, must be below `n_i` |
| e_i | input | EW | Exponent |
| n_i | input | W | Modulus, odd and greater than 1 |
| nbits_i | input | $clog2(EW+1) | Number of exponent bits used |
| res_o | output | W | Result, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Random odd moduli with random bases and full-length exponents are run in private mode. They are compared with a square-and-multiply reference, and the cycle counts are compared with each other. Any cycle count that varies with the data exposes a dependence of timing on values. Public-mode runs with random lengths use the same reference, and they show whether skipping products is ever mistaken for dropping a result update. Directed cases cover these points: a zero length; a length above the exponent width; exponents with stray high bits; bases of 0 and `N-1`; the smallest and largest moduli; and a start strobe pulsed in the middle of an operation. Each one separates a specific mistake: wrong initial values, clamping errors, bits that leak in, reduction overflow, and a busy guard that is missing.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FIN   = 2'd3
   } mx_state_e;
endpackage

// File: rtl/modexp_mulred.sv
// Interleaved shift-add-reduce modular multiplier: one bit of b per cycle,
// most significant first. Fixed latency of W cycles after the load edge.
module modexp_mulred #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] n,
   output logic [W-1:0] prod,
   output logic         done
);
   localparam int CW = $clog2(W + 1);
   localparam int AW = W + 2;

   logic [W-1:0]  acc_q, a_q, b_q, n_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic [AW-1:0] dbl, addend, sum, s1, nn;
   logic [W-1:0]  acc_nx;

   always_comb begin
      nn     = {2'b00, n_q};
      dbl    = {1'b0, acc_q, 1'b0};
      addend = b_q[W-1] ? {2'b00, a_q} : '0;
      sum    = dbl + addend;
      s1     = (sum >= nn) ? sum - nn : sum;
      acc_nx = (s1 >= nn) ? W'(s1 - nn) : W'(s1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         n_q    <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            acc_q  <= '0;
            a_q    <= a;
            b_q    <= b;
            n_q    <= n;
            cnt_q  <= CW'(W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            acc_q <= acc_nx;
            b_q   <= b_q << 1;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign prod = acc_q;
endmodule

// File: rtl/modexp_expscan.sv
// Exponent scanner: presents the current low bit and counts remaining steps.
module modexp_expscan #(
   parameter int EW = 32,
   localparam int KW = $clog2(EW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [EW-1:0] e,
   input  logic [KW-1:0] k,
   input  logic          step,
   output logic          bit_o,
   output logic          last_o,
   output logic          zero_o
);
   logic [EW-1:0] sh_q;
   logic [KW-1:0] left_q, k_eff;

   assign k_eff  = (k > KW'(EW)) ? KW'(EW) : k;
   assign zero_o = (k == '0);
   assign bit_o  = sh_q[0];
   assign last_o = (left_q == KW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= e;
         left_q <= k_eff;
      end else if (step) begin
         sh_q   <= sh_q >> 1;
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/modexp_top.sv
module modexp_top
   import modexp_pkg::*;
#(
   parameter int W  = 32,
   parameter int EW = 32,
   localparam int KW = $clog2(EW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          priv_i,
   input  logic [W-1:0]  m_i,
   input  logic [EW-1:0] e_i,
   input  logic [W-1:0]  n_i,
   input  logic [KW-1:0] nbits_i,
   output logic [W-1:0]  res_o,
   output logic          done_o
);
   if (W < 2) begin : g_bad_w
      $error("modexp_top: W must be at least 2");
   end
   if (EW < 1) begin : g_bad_ew
      $error("modexp_top: EW must be at least 1");
   end

   mx_state_e    state_q;
   logic [W-1:0] r_q, p_q, n_q, res_q;
   logic         priv_q;
   logic         ebit, elast, ezero, load, step, issue, unit_done;
   logic [1:0]   go, mdone;
   logic [W-1:0] op_a [2];
   logic [W-1:0] op_b [2];
   logic [W-1:0] prod [2];

   assign load      = (state_q == ST_IDLE) && start_i;
   assign issue     = (state_q == ST_ISSUE);
   assign unit_done = |mdone;
   assign step      = (state_q == ST_WAIT) && unit_done;

   // unit 0: result times power; unit 1: power squared
   assign go[0]   = issue && (priv_q || ebit);
   assign go[1]   = issue;
   assign op_a[0] = r_q;
   assign op_b[0] = p_q;
   assign op_a[1] = p_q;
   assign op_b[1] = p_q;

   for (genvar u = 0; u < 2; u++) begin : g_unit
      modexp_mulred #(.W(W)) u_mul (
         .clk  (clk),
         .rst_n(rst_n),
         .go   (go[u]),
         .a    (op_a[u]),
         .b    (op_b[u]),
         .n    (n_q),
         .prod (prod[u]),
         .done (mdone[u])
      );
   end

   modexp_expscan #(.EW(EW)) u_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .e     (e_i),
      .k     (nbits_i),
      .step  (step),
      .bit_o (ebit),
      .last_o(elast),
      .zero_o(ezero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         r_q     <= '0;
         p_q     <= '0;
         n_q     <= '0;
         res_q   <= '0;
         priv_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               n_q    <= n_i;
               priv_q <= priv_i;
               r_q    <= W'(1);
               p_q    <= m_i;
               if (ezero) begin
                  res_q   <= W'(1);
                  state_q <= ST_FIN;
               end else begin
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: if (unit_done) begin
               p_q <= prod[1];
               if (ebit) r_q <= prod[0];
               if (elast) begin
                  res_q   <= ebit ? prod[0] : r_q;
                  state_q <= ST_FIN;
               end else begin
                  state_q <= ST_ISSUE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign res_o  = res_q;
   assign done_o = (state_q == ST_FIN);
endmodule

// File: rtl/modexp_chk.sv
module modexp_chk
   import modexp_pkg::*;
#(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         done_o,
   input logic [W-1:0] res_o,
   input logic [W-1:0] n_q,
   input logic [W-1:0] p_q,
   input mx_state_e    state_q,
   input logic [1:0]   mdone,
   input logic         priv_q,
   input logic         ebit
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(res_o)); // R7
   AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (res_o < n_q)); // R9
   AST_POW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> (p_q < n_q)); // R9
   AST_MUL_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && mdone[1]) |-> (mdone[0] == (priv_q || ebit))); // R6
   AST_SQ_EACH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && mdone[0]) |-> mdone[1]); // R6
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start_i) |=> $stable(n_q)); // R8
endmodule

bind modexp_top modexp_chk #(.W(W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .done_o (done_o),
   .res_o  (res_o),
   .n_q    (n_q),
   .p_q    (p_q),
   .state_q(state_q),
   .mdone  (mdone),
   .priv_q (priv_q),
   .ebit   (ebit)
);

// File: tb/tb_modexp_top.sv
`timescale 1ns/1ps
module tb_modexp_top;
   localparam int W  = 16;
   localparam int EW = 16;
   localparam int KW = $clog2(EW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          priv_i = 1'b0;
   logic [W-1:0]  m_i = '0;
   logic [EW-1:0] e_i = '0;
   logic [W-1:0]  n_i = '0;
   logic [KW-1:0] nbits_i = '0;
   logic [W-1:0]  res_o;
   logic          done_o;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   int priv_lat = -1;

   always #2.5 clk = ~clk;

   modexp_top #(.W(W), .EW(EW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .priv_i(priv_i),
      .m_i(m_i), .e_i(e_i), .n_i(n_i), .nbits_i(nbits_i),
      .res_o(res_o), .done_o(done_o)
   );

   function automatic longint unsigned ref_pow(longint unsigned m, longint unsigned e,
                                               longint unsigned n, int k);
      longint unsigned r = 1 % n;
      longint unsigned p = m;
      for (int i = 0; i < k; i++) begin
         if (e[i]) r = (r * p) % n;
         p = (p * p) % n;
      end
      return r;
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run(logic [W-1:0] m, logic [EW-1:0] e, logic [W-1:0] n,
                      int k, bit priv, bit poke, string req);
      int cyc;
      int keff;
      logic [W-1:0] held;
      longint unsigned exp;
      keff = (k > EW) ? EW : k;
      exp  = ref_pow(m, e, n, keff);
      @(negedge clk);
      m_i = m; e_i = e; n_i = n; nbits_i = KW'(k); priv_i = priv; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      cyc = 1;
      while (!done_o) begin
         if (poke && cyc == 5) begin
            start_i = 1'b1; m_i = ~m; n_i = n ^ 16'h0006; nbits_i = KW'(1);
         end else begin
            start_i = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      check(res_o == W'(exp), req, "result", res_o, exp);
      check(cyc == keff * (W + 2) + 1, "R5", "latency", cyc, keff * (W + 2) + 1);
      if (priv && keff == EW) begin
         if (priv_lat < 0) priv_lat = cyc;
         check(cyc == priv_lat, "R5", "private latency vs first", cyc, priv_lat);
      end
      held = res_o;
      @(posedge clk);
      @(negedge clk);
      check(!done_o, "R7", "done single pulse", done_o, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(res_o == held, "R7", "result held", res_o, held);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] n, m;
      logic [EW-1:0] e;
      int k;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
      check(res_o == '0, "R1", "result after reset", res_o, 0);
      rst_n = 1'b1;

      // directed corners
      run(16'd5, 16'h00FF, 16'd11, 0, 1'b1, 1'b0, "R3");
      run(16'd5, 16'h00FF, 16'd11, 0, 1'b0, 1'b0, "R3");
      run(16'd7, 16'hFFE5, 16'd13, 5, 1'b1, 1'b0, "R4");
      run(16'd7, 16'hFFE5, 16'd13, 5, 1'b0, 1'b0, "R4");
      run(16'd3, 16'hBEEF, 16'd1001, 20, 1'b1, 1'b0, "R4");
      run(16'd0, 16'h0004, 16'd97, 2, 1'b1, 1'b0, "R2");
      run(16'd0, 16'h0006, 16'd97, 3, 1'b0, 1'b0, "R2");
      run(16'd65534, 16'hFFFF, 16'd65535, 16, 1'b1, 1'b0, "R9");
      run(16'd2, 16'hFFFF, 16'd3, 16, 1'b0, 1'b0, "R9");
      run(16'd1234, 16'hA5A5, 16'd40001, 16, 1'b1, 1'b1, "R8");
      run(16'd1234, 16'h0001, 16'd40001, 16, 1'b0, 1'b1, "R8");

      // random private runs, full length
      for (int i = 0; i < 24; i++) begin
         n = W'($urandom) | 16'h0001;
         if (n < 16'd3) n = 16'd3;
         m = W'($urandom % n);
         e = EW'($urandom);
         run(m, e, n, EW, 1'b1, 1'b0, "R2");
      end
      // random public runs, random length (R6 mode encoding)
      for (int i = 0; i < 16; i++) begin
         n = W'($urandom) | 16'h0001;
         if (n < 16'd3) n = 16'd3;
         m = W'($urandom % n);
         e = EW'($urandom);
         k = 1 + int'($urandom % EW);
         run(m, e, n, k, 1'b0, 1'b0, "R6");
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule